// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block sequences power-down for a small microcontroller core. The instruction decoder gives it a one-cycle sleep strobe. The block checks whether any interrupt source already has both its flag and its enable set. If one does, the sleep becomes a no-op. If none does, the block turns the oscillator enable off, stalls the core, pulses a watchdog-clear, and updates two sticky status bits: a power-down bit and a time-out bit.

While asleep, the wake condition is a plain combinational OR of the flag-and-enable terms and the watchdog time-out, because no clock is assumed to run. A wake event turns the oscillator enable back on. The core then stays stalled for a fixed settle count. After the stall is released, the core gets one cycle to run the instruction that follows the sleep. If the global interrupt enable was set when the wake happened, a one-cycle request to branch to the interrupt vector follows. An external reset returns the sequencer to running and raises a core reset, and leaves the status bits as they were, so software can read what happened.

The watchdog counter, the interrupt sources and the pipeline are outside the block. Every pin is a plain control or status level or a one-cycle pulse. There is no streaming data and no handshake.

Top module: `slpw_ctrl`

## Requirements
- R1: After power-on reset: pd_o=1, to_o=1, osc_en_o=1, stall_o=0, and wdt_clr_o, vec_req_o and core_rst_o are all 0.
- R2: A sleep strobe accepted while running, with no enabled interrupt pending in that same cycle, gives the following in the next cycle: osc_en_o=0, stall_o=1, wdt_clr_o=1 for exactly one cycle, pd_o=0 and to_o=1.
- R3: A sleep strobe in a cycle where some source has both flag and enable set is a no-op: the oscillator stays on, there is no stall, no watchdog-clear, and pd_o and to_o keep their values.
- R4: An enabled interrupt that appears after the sleep strobe was accepted lets the sleep finish fully (pd_o=0, watchdog cleared), and the block wakes at the next clock edge.
- R5: A source wakes the block only when its own enable bit is set. The global enable gie_i plays no part in waking.
- R6: On wake, osc_en_o returns to 1 at once. stall_o stays 1 for SETTLE_CYCLES (default 4) cycles with the oscillator on, and then falls.
- R7: One cycle after stall_o falls, vec_req_o pulses for one cycle if the wake was by interrupt and gie_i was 1 at the wake edge. Otherwise vec_req_o stays 0.
- R8: A watchdog time-out while asleep wakes the block and clears to_o. pd_o stays 0.
- R9: ext_rst_i gives core_rst_o=1 in the next cycle and returns the block to running (osc_en_o=1, stall_o=0). pd_o and to_o are kept.
- R10: While running, clrwdt_i (without a sleep strobe that enters sleep) sets pd_o=1 and to_o=1 and pulses wdt_clr_o. While stall_o=1, clrwdt_i has no effect.
- R11: A watchdog time-out while running has no effect on any output.
- R12: wake_o is 1 exactly while asleep and an enabled interrupt or a watchdog time-out is present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_n_i | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req_i | input | 1 | Sleep strobe from the decoder |
| clrwdt_i | input | 1 | Software clear-watchdog command |
| irq_flag_i | input | NUM_SRC | Per-source interrupt flags |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| wdt_timeout_i | input | 1 | Watchdog time-out pulse |
| ext_rst_i | input | 1 | External reset request |
| osc_en_o | output | 1 | Oscillator enable |
| stall_o | output | 1 | Core stall |
| wdt_clr_o | output | 1 | Watchdog and postscaler clear pulse |
| vec_req_o | output | 1 | Interrupt vector branch request |
| core_rst_o | output | 1 | Full device reset request |
| wake_o | output | 1 | Raw combinational wake condition |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |

## Verification
Most faults in the state register show up at osc_en_o or stall_o within one cycle of the next strobe or wake event. Examples are taking the no-op path for the wrong cycle, or missing a wake. A wrong settle count moves the falling edge of stall_o, and a wrong latched vector flag shows up as a missing or extra vec_req_o pulse. Both appear a few cycles after the wake. A behavioural model in the bench predicts every output on every cycle, so a divergence is caught in the cycle where it first appears.

// File: rtl/slpw_pkg.sv
package slpw_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RESUME = 2'd3
  } slpw_state_e;
endpackage

// File: rtl/slpw_wake_detect.sv
module slpw_wake_detect #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               pend_o
);
  logic [NUM_SRC-1:0] hit;

  // one flag-and-enable term per source; no clock involved
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_term
    assign hit[g] = flag_i[g] & en_i[g];
  end

  assign pend_o = |hit;
endmodule

// File: rtl/slpw_settle_cnt.sv
module slpw_settle_cnt #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)              cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/slpw_status.sv
module slpw_status (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic enter_i,
  input  logic wdt_wake_i,
  input  logic sw_clr_i,
  output logic pd_o,
  output logic to_o
);
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pd_o <= 1'b1;
      to_o <= 1'b1;
    end else if (enter_i) begin
      pd_o <= 1'b0;
      to_o <= 1'b1;
    end else if (sw_clr_i) begin
      pd_o <= 1'b1;
      to_o <= 1'b1;
    end else if (wdt_wake_i) begin
      to_o <= 1'b0;
    end
  end
endmodule

// File: rtl/slpw_ctrl.sv
module slpw_ctrl
  import slpw_pkg::*;
#(
  parameter int NUM_SRC       = 8,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               sleep_req_i,
  input  logic               clrwdt_i,
  input  logic [NUM_SRC-1:0] irq_flag_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               gie_i,
  input  logic               wdt_timeout_i,
  input  logic               ext_rst_i,
  output logic               osc_en_o,
  output logic               stall_o,
  output logic               wdt_clr_o,
  output logic               vec_req_o,
  output logic               core_rst_o,
  output logic               wake_o,
  output logic               pd_o,
  output logic               to_o
);
  slpw_state_e st_q;
  logic pend, run_like, enter, sw_clr, wake_raw, wake_go, wdt_wake;
  logic settle_run, settle_done, vec_arm_q;

  slpw_wake_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .flag_i (irq_flag_i),
    .en_i   (irq_en_i),
    .pend_o (pend)
  );

  // the pending check and the strobe share one cycle: that cycle decides no-op or sleep
  assign run_like = (st_q == ST_RUN) || (st_q == ST_RESUME);
  assign enter    = run_like && sleep_req_i && !pend && !ext_rst_i;
  assign sw_clr   = run_like && clrwdt_i && !enter && !ext_rst_i;
  assign wake_raw = (st_q == ST_SLEEP) && (pend || wdt_timeout_i);
  assign wake_go  = wake_raw && !ext_rst_i;
  assign wdt_wake = wake_go && wdt_timeout_i;
  assign wake_o   = wake_raw;

  assign settle_run = (st_q == ST_SETTLE) && !ext_rst_i;

  slpw_settle_cnt #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .run_i  (settle_run),
    .done_o (settle_done)
  );

  slpw_status u_status (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .enter_i    (enter),
    .wdt_wake_i (wdt_wake),
    .sw_clr_i   (sw_clr),
    .pd_o       (pd_o),
    .to_o       (to_o)
  );

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q       <= ST_RUN;
      osc_en_o   <= 1'b1;
      stall_o    <= 1'b0;
      wdt_clr_o  <= 1'b0;
      vec_req_o  <= 1'b0;
      core_rst_o <= 1'b0;
      vec_arm_q  <= 1'b0;
    end else begin
      core_rst_o <= ext_rst_i;
      wdt_clr_o  <= enter || sw_clr;
      vec_req_o  <= 1'b0;
      if (ext_rst_i) begin
        st_q      <= ST_RUN;
        osc_en_o  <= 1'b1;
        stall_o   <= 1'b0;
        vec_arm_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RUN, ST_RESUME: begin
            if (st_q == ST_RESUME) begin
              // the instruction after the sleep ran in this cycle
              vec_req_o <= vec_arm_q;
              vec_arm_q <= 1'b0;
              st_q      <= ST_RUN;
            end
            if (enter) begin
              st_q     <= ST_SLEEP;
              osc_en_o <= 1'b0;
              stall_o  <= 1'b1;
            end
          end
          ST_SLEEP: begin
            if (wake_go) begin
              st_q      <= ST_SETTLE;
              osc_en_o  <= 1'b1;
              vec_arm_q <= pend && gie_i;
            end
          end
          ST_SETTLE: begin
            if (settle_done) begin
              st_q    <= ST_RESUME;
              stall_o <= 1'b0;
            end
          end
          default: st_q <= ST_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/slpw_ctrl_chk.sv
module slpw_ctrl_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk_i,
  input logic               rst_n_i,
  input logic               sleep_req_i,
  input logic               clrwdt_i,
  input logic [NUM_SRC-1:0] irq_flag_i,
  input logic [NUM_SRC-1:0] irq_en_i,
  input logic               wdt_timeout_i,
  input logic               ext_rst_i,
  input logic               osc_en_o,
  input logic               stall_o,
  input logic               wdt_clr_o,
  input logic               vec_req_o,
  input logic               core_rst_o,
  input logic               pd_o,
  input logic               to_o
);
  logic any_pend;
  logic running, asleep;
  assign any_pend = |(irq_flag_i & irq_en_i);
  assign running  = osc_en_o && !stall_o;
  assign asleep   = !osc_en_o && stall_o;

  assert_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (running && sleep_req_i && !any_pend && !ext_rst_i)
      |=> (!osc_en_o && stall_o && wdt_clr_o && !pd_o && to_o));

  assert_noop_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (running && sleep_req_i && any_pend && !clrwdt_i && !ext_rst_i)
      |=> (osc_en_o && !stall_o && !wdt_clr_o && $stable(pd_o) && $stable(to_o)));

  assert_irq_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (asleep && any_pend && !ext_rst_i) |=> (osc_en_o && stall_o));

  assert_osc_off_stalls_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !osc_en_o |-> stall_o);

  assert_vec_after_release_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(vec_req_o) |-> (!stall_o && $past(!stall_o) && osc_en_o));

  assert_wdt_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (asleep && wdt_timeout_i && !ext_rst_i) |=> (!to_o && !pd_o && osc_en_o));

  assert_ext_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ext_rst_i |=> (core_rst_o && osc_en_o && !stall_o && $stable(pd_o) && $stable(to_o)));

  assert_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (running && clrwdt_i && !sleep_req_i && !ext_rst_i) |=> (pd_o && to_o && wdt_clr_o));
endmodule

bind slpw_ctrl slpw_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk_i         (clk_i),
  .rst_n_i       (rst_n_i),
  .sleep_req_i   (sleep_req_i),
  .clrwdt_i      (clrwdt_i),
  .irq_flag_i    (irq_flag_i),
  .irq_en_i      (irq_en_i),
  .wdt_timeout_i (wdt_timeout_i),
  .ext_rst_i     (ext_rst_i),
  .osc_en_o      (osc_en_o),
  .stall_o       (stall_o),
  .wdt_clr_o     (wdt_clr_o),
  .vec_req_o     (vec_req_o),
  .core_rst_o    (core_rst_o),
  .pd_o          (pd_o),
  .to_o          (to_o)
);

// File: tb/slpw_ctrl_tb_top.sv
`timescale 1ns/1ps
module slpw_ctrl_tb_top;
  localparam int N  = 8;
  localparam int ST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, clrwdt = 1'b0, gie = 1'b0, wdt_to = 1'b0, ext_rst = 1'b0;
  logic [N-1:0] flag = '0, en = '0;
  logic osc_en, stall, wdt_clr, vec_req, core_rst, wake, pd, to;

  always #2.5 clk = ~clk;

  slpw_ctrl #(.NUM_SRC(N), .SETTLE_CYCLES(ST)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .sleep_req_i(sleep_req), .clrwdt_i(clrwdt),
    .irq_flag_i(flag), .irq_en_i(en), .gie_i(gie), .wdt_timeout_i(wdt_to),
    .ext_rst_i(ext_rst), .osc_en_o(osc_en), .stall_o(stall), .wdt_clr_o(wdt_clr),
    .vec_req_o(vec_req), .core_rst_o(core_rst), .wake_o(wake), .pd_o(pd), .to_o(to)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // behavioural model: phase 0 awake, 1 asleep, 2 settling, 3 first cycle after release
  int  m_phase = 0, m_left = 0;
  bit  m_osc = 1, m_stall = 0, m_clr = 0, m_vec = 0, m_rst = 0, m_pd = 1, m_to = 1, m_arm = 0;
  bit  started = 0;

  always @(posedge clk) begin
    bit p;
    p = (flag & en) != 0;
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_osc = 1; m_stall = 0; m_clr = 0; m_vec = 0;
      m_rst = 0; m_pd = 1; m_to = 1; m_arm = 0;
    end else begin
      started = 1;
      m_rst = ext_rst; m_vec = 0; m_clr = 0;
      if (ext_rst) begin
        m_phase = 0; m_osc = 1; m_stall = 0; m_arm = 0;
      end else if (m_phase == 0 || m_phase == 3) begin
        if (m_phase == 3) begin m_vec = m_arm; m_arm = 0; m_phase = 0; end
        if (sleep_req && !p) begin
          m_phase = 1; m_osc = 0; m_stall = 1; m_clr = 1; m_pd = 0; m_to = 1;
        end else if (clrwdt) begin
          m_clr = 1; m_pd = 1; m_to = 1;
        end
      end else if (m_phase == 1) begin
        if (p || wdt_to) begin
          m_phase = 2; m_osc = 1; m_left = ST; m_arm = p && gie;
          if (wdt_to) m_to = 0;
        end
      end else begin
        m_left = m_left - 1;
        if (m_left == 0) begin m_phase = 3; m_stall = 0; end
      end
    end
  end

  task automatic chk(input string nm, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  // compare every cycle at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk("osc_en", osc_en, m_osc);
      chk("stall", stall, m_stall);
      chk("wdt_clr", wdt_clr, m_clr);
      chk("vec_req", vec_req, m_vec);
      chk("core_rst", core_rst, m_rst);
      chk("pd", pd, m_pd);
      chk("to", to, m_to);
      chk("wake_R12", wake, (m_phase == 1) && (((flag & en) != 0) || wdt_to));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_sleep();  sleep_req = 1; tick(1); sleep_req = 0; endtask
  task automatic pulse_clr();    clrwdt = 1;    tick(1); clrwdt = 0;    endtask
  task automatic pulse_wdt();    wdt_to = 1;    tick(1); wdt_to = 0;    endtask
  task automatic pulse_ext();    ext_rst = 1;   tick(1); ext_rst = 0;   endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1;
    cur_req = "R1"; tick(2);
    // R2 plain entry
    cur_req = "R2"; pulse_sleep(); tick(3);
    // R5 flag without its enable does not wake, gie irrelevant
    cur_req = "R5"; flag = 8'h04; gie = 1; tick(4);
    en = 8'h04;
    cur_req = "R6"; tick(6);
    cur_req = "R7"; tick(3);
    flag = '0; en = '0;
    // R10 software clear while running
    cur_req = "R10"; pulse_clr(); tick(2);
    // R3 no-op when pending in the strobe cycle
    cur_req = "R3"; flag = 8'h01; en = 8'h01; pulse_sleep(); tick(3);
    flag = '0; en = '0;
    // R4 interrupt appears after acceptance, gie clear -> no vector
    cur_req = "R4"; gie = 0; pulse_sleep();
    flag = 8'h02; en = 8'h82; tick(9);
    flag = '0; en = '0;
    // R8 watchdog wake
    cur_req = "R8"; gie = 1; pulse_sleep(); tick(3); pulse_wdt(); tick(8);
    // R11 watchdog while running
    cur_req = "R11"; pulse_wdt(); tick(3);
    // R9 external reset while asleep and while settling
    cur_req = "R9"; pulse_sleep(); tick(2); pulse_ext(); tick(3);
    pulse_sleep(); pulse_wdt(); tick(1); pulse_ext(); tick(3);
    // R10 clear ignored while stalled
    cur_req = "R10"; pulse_sleep(); tick(2); pulse_clr(); tick(2); pulse_ext(); tick(2);
    // R12 raw wake only with enable
    cur_req = "R12"; pulse_sleep(); flag = 8'h10; tick(3); en = 8'h10; tick(1);
    flag = '0; en = '0; tick(8);
    finish_run();
  end
endmodule